// File: doc/BRIEF.md
# Streaming Final Butterfly Stage

This block closes a streaming pipelined FFT. Complex samples arrive one per enabled clock. Each word holds a real and an imaginary two's-complement component. The block groups the stream into consecutive pairs, starting from the sample that carries the frame sync. For each pair it emits the sum first and the difference on the next enabled clock, so the output rate equals the input rate. One adder pair per component does both results over time. Each output component is one bit wider than the input, so no result can overflow.

A small sequencer decides whether each sample opens or closes a pair. It has three states:

- `ST_IDLE`: not yet locked to a frame.
- `ST_EVEN`: the next sample opens a pair.
- `ST_ODD`: the next sample closes a pair.

Its transitions are:

- Reset takes it to `ST_IDLE`.
- An enabled sync goes to `ST_ODD` from any state.
- An enabled sample moves `ST_EVEN` to `ST_ODD`.
- An enabled sample without sync moves `ST_ODD` to `ST_EVEN`.
- `ST_IDLE` stays put until a sync arrives.

A frame counter raises an output marker on the first result of each frame. The marker repeats every `FRAME_LEN` results.

Top module: `fft_tail_butterfly`

## Requirements
- R1: Input word `din` carries the real part in bits [2*IW-1:IW] and the imaginary part in bits [IW-1:0], both two's complement; the two parts are processed independently.
- R2: Output word `dout` carries the real part in bits [2*OW-1:OW] and the imaginary part in bits [OW-1:0], with OW = IW+1; sums and differences of full-scale inputs appear without wrap-around.
- R3: For a pair (x[n], x[n+1]), with n even when counted from the sample that carried the sync, `dout` shows x[n]+x[n+1] per component.
- R4: On the enabled clock after the sum, `dout` shows x[n]-x[n+1] per component.
- R5: An enabled `sync_in` makes its sample the first of a new pair, even if a pair was half complete; the half pair is dropped.
- R6: `sync_out` is high exactly while `dout` holds the first result of a frame, and again every FRAME_LEN results after it without a further sync (FRAME_LEN = 128 by default).
- R7: While `en` is low, `din` and `sync_in` are ignored and `dout` and `sync_out` hold their values.
- R8: After a synchronous active-high `rst`, `dout` is zero and `sync_out` low, and both stay so until the first enabled `sync_in`; data before it has no effect.
- R9: The sum of a pair appears after the enabled edge that accepts x[n+1]. The enabled edge that accepts x[n] still shows the previous difference (zero right after lock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; one sample per enabled clock |
| sync_in | input | 1 | Frame start marker, one sample long |
| din | input | 2*IW | Packed complex input {real, imag} |
| dout | output | 2*(IW+1) | Packed complex result {real, imag} |
| sync_out | output | 1 | High on the first result of each frame |

## Verification
A wrong pairing phase in the sequencer shows at once: the next sum slot carries x[n+1]+x[n+2] instead of x[n]+x[n+1], and every following result is wrong. A wrong frame counter moves `sync_out` off its slot. That error may stay hidden until the next frame boundary, up to FRAME_LEN results later, so the bench runs several whole frames. A stale held sample or a lost pending difference shows on the first difference slot after the fault. The bench sweeps full-scale corner values on both components, so a missing sign extension shows as a wrong sign or magnitude in the extreme cases.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    // Pairing sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for the first frame marker
        ST_EVEN = 2'd1,   // next sample opens a pair
        ST_ODD  = 2'd2    // next sample closes a pair
    } bfly_state_t;
endpackage

// File: rtl/bfly_lane.sv
// One component of the butterfly: widened sum and difference.
module bfly_lane #(
    parameter int IW = 8,
    localparam int OW = IW + 1
) (
    input  logic [IW-1:0] a,
    input  logic [IW-1:0] b,
    output logic [OW-1:0] sum,
    output logic [OW-1:0] diff
);
    logic [OW-1:0] a_w, b_w;

    always_comb begin
        a_w  = {a[IW-1], a};
        b_w  = {b[IW-1], b};
        sum  = a_w + b_w;
        diff = a_w - b_w;
    end
endmodule

// File: rtl/bfly_seq.sv
// Pairing sequencer: decides whether each accepted sample opens or closes a pair.
module bfly_seq
    import bfly_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sync_in,
    output logic take_even,
    output logic take_odd,
    output logic locked
);
    bfly_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (en) begin
            if (sync_in) begin
                state_d = ST_ODD;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = ST_IDLE;
                    ST_EVEN: state_d = ST_ODD;
                    ST_ODD:  state_d = ST_EVEN;
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        take_even = 1'b0;
        take_odd  = 1'b0;
        locked    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take_even = en && sync_in;
            end
            ST_EVEN: begin
                locked    = 1'b1;
                take_even = en;
            end
            ST_ODD: begin
                locked    = 1'b1;
                take_even = en && sync_in;
                take_odd  = en && !sync_in;
            end
            default: begin
                locked = 1'b0;
            end
        endcase
    end

    AST_SYNC_LOCKS: assert property (@(posedge clk) disable iff (rst)
        en && sync_in |=> state_q == ST_ODD) else $error("sync did not open a pair"); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE && !(en && sync_in) |=> state_q == ST_IDLE) else $error("left idle without sync"); // R8

    AST_PAIR_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_EVEN && en |=> state_q == ST_ODD) else $error("even sample did not open a pair"); // R3
endmodule

// File: rtl/bfly_datapath.sv
// Held first sample, pending difference and output register.
module bfly_datapath #(
    parameter int IW = 8,
    localparam int OW = IW + 1,
    localparam int NCOMP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              take_even,
    input  logic              take_odd,
    input  logic [2*IW-1:0]   din,
    output logic [2*OW-1:0]   dout
);
    logic [2*IW-1:0] held_q;
    logic [2*OW-1:0] sum_w, diff_w;
    logic [2*OW-1:0] pend_q;
    logic [2*OW-1:0] out_q;
    logic            sum_slot_q;

    // Component 0 is imaginary (low bits), component 1 is real (high bits)
    for (genvar c = 0; c < NCOMP; c++) begin : g_lane
        bfly_lane #(.IW(IW)) u_lane (
            .a    (held_q[c*IW +: IW]),
            .b    (din[c*IW +: IW]),
            .sum  (sum_w[c*OW +: OW]),
            .diff (diff_w[c*OW +: OW])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q     <= '0;
            pend_q     <= '0;
            out_q      <= '0;
            sum_slot_q <= 1'b0;
        end else if (en) begin
            if (take_even) begin
                held_q <= din;
            end
            if (take_odd) begin
                out_q  <= sum_w;
                pend_q <= diff_w;
            end else begin
                out_q  <= pend_q;
            end
            sum_slot_q <= take_odd;
        end
    end

    assign dout = out_q;

    // Sum followed by difference must add up to twice the first sample.
    logic [OW:0] tot_re, tot_im, twice_re, twice_im;
    assign tot_re   = {out_q[2*OW-1], out_q[2*OW-1:OW]};
    assign tot_im   = {out_q[OW-1], out_q[OW-1:0]};
    assign twice_re = {held_q[2*IW-1], held_q[2*IW-1:IW], 1'b0};
    assign twice_im = {held_q[IW-1], held_q[IW-1:0], 1'b0};

    AST_SUM_DIFF_PAIR_RE: assert property (@(posedge clk) disable iff (rst)
        en && sum_slot_q |=> (tot_re + $past(tot_re)) == $past(twice_re)) else $error("real pair mismatch"); // R4

    AST_SUM_DIFF_PAIR_IM: assert property (@(posedge clk) disable iff (rst)
        en && sum_slot_q |=> (tot_im + $past(tot_im)) == $past(twice_im)) else $error("imag pair mismatch"); // R4
endmodule

// File: rtl/bfly_frame_ctr.sv
// Frame position counter and output marker. FRAME_LEN must be a power of two, at least 2.
module bfly_frame_ctr #(
    parameter int FRAME_LEN = 128,
    localparam int LG = $clog2(FRAME_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sync_in,
    input  logic locked,
    input  logic take_odd,
    output logic sync_out
);
    localparam logic [LG-1:0] IDX_FIRST_ODD = LG'(1);
    localparam logic [LG-1:0] IDX_AFTER     = LG'(2);

    logic [LG-1:0] idx_q;
    logic          mark_q;
    logic          mark_w;

    assign mark_w = take_odd && (idx_q == IDX_FIRST_ODD);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            mark_q <= 1'b0;
        end else if (en) begin
            if (sync_in) begin
                idx_q <= IDX_FIRST_ODD;
            end else if (locked) begin
                idx_q <= idx_q + 1'b1;
            end
            mark_q <= mark_w;
        end
    end

    assign sync_out = mark_q;

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        en && sync_in |=> idx_q == IDX_FIRST_ODD) else $error("counter not realigned"); // R5

    AST_MARK_POSITION: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> idx_q == IDX_AFTER) else $error("marker off frame start"); // R6
endmodule

// File: rtl/fft_tail_butterfly.sv
module fft_tail_butterfly #(
    parameter int IW = 8,
    parameter int FRAME_LEN = 128,
    localparam int OW = IW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            sync_in,
    input  logic [2*IW-1:0] din,
    output logic [2*OW-1:0] dout,
    output logic            sync_out
);
    logic take_even, take_odd, locked;

    bfly_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .sync_in   (sync_in),
        .take_even (take_even),
        .take_odd  (take_odd),
        .locked    (locked)
    );

    bfly_datapath #(.IW(IW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .take_even (take_even),
        .take_odd  (take_odd),
        .din       (din),
        .dout      (dout)
    );

    bfly_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sync_in  (sync_in),
        .locked   (locked),
        .take_odd (take_odd),
        .sync_out (sync_out)
    );

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout) && $stable(sync_out)) else $error("output moved while stalled"); // R7

    AST_QUIET_BEFORE_LOCK: assert property (@(posedge clk) disable iff (rst)
        !locked |-> dout == '0 && !sync_out) else $error("output before lock"); // R8
endmodule

// File: tb/fft_tail_butterfly_test.sv
`timescale 1ns/1ps
module fft_tail_butterfly_test;
    localparam int IW = 8;
    localparam int OW = IW + 1;
    localparam int FRAME_LEN = 128;

    logic clk = 1'b0;
    logic rst, en, sync_in;
    logic [2*IW-1:0] din;
    logic [2*OW-1:0] dout;
    logic sync_out;

    always #2.5 clk = ~clk;

    fft_tail_butterfly #(.IW(IW), .FRAME_LEN(FRAME_LEN)) uut (
        .clk(clk), .rst(rst), .en(en), .sync_in(sync_in),
        .din(din), .dout(dout), .sync_out(sync_out)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Requirement-level model state
    int m_lock, m_odd, m_are, m_aim, m_pre, m_pim, m_idx;
    int e_re, e_im, e_sync;
    string tag_force = "";

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int out_re();
        return int'($signed(dout[2*OW-1:OW]));
    endfunction

    function automatic int out_im();
        return int'($signed(dout[OW-1:0]));
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic model_clear();
        m_lock = 0; m_odd = 0; m_are = 0; m_aim = 0;
        m_pre = 0; m_pim = 0; m_idx = 0;
        e_re = 0; e_im = 0; e_sync = 0;
    endtask

    // Drive one clock (called at a falling edge), then check at the next falling edge.
    task automatic step(bit e, bit s, int re, int im);
        string tg, tgs;
        en      = e;
        sync_in = s;
        din     = {re[IW-1:0], im[IW-1:0]};
        if (!e) begin
            tg = "R7"; tgs = "R7";
        end else if (s) begin
            e_re = m_pre; e_im = m_pim; e_sync = 0;
            m_are = re; m_aim = im; m_odd = 1; m_idx = 1; m_lock = 1;
            tg = "R5"; tgs = "R5";
        end else if (!m_lock) begin
            e_re = m_pre; e_im = m_pim; e_sync = 0;
            tg = "R8"; tgs = "R8";
        end else if (m_odd) begin
            e_re = m_are + re; e_im = m_aim + im;
            m_pre = m_are - re; m_pim = m_aim - im;
            e_sync = (m_idx == 1);
            m_idx = (m_idx + 1) % FRAME_LEN;
            m_odd = 0;
            tg = "R3"; tgs = "R6";
        end else begin
            e_re = m_pre; e_im = m_pim; e_sync = 0;
            m_are = re; m_aim = im; m_odd = 1;
            m_idx = (m_idx + 1) % FRAME_LEN;
            tg = "R4"; tgs = "R6";
        end
        if (e && m_lock && (iabs(e_re) > (1 << (IW-1)) - 1 || iabs(e_im) > (1 << (IW-1)) - 1))
            tg = "R2";
        if (tag_force != "") tg = tag_force;
        @(posedge clk);
        @(negedge clk);
        chk({tg, " real"}, out_re(), e_re);
        chk({tg, " imag"}, out_im(), e_im);
        chk({tgs, " sync_out"}, int'(sync_out), e_sync);
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; sync_in = 1'b0; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk("R8 reset real", out_re(), 0);
        chk("R8 reset imag", out_im(), 0);
        chk("R8 reset sync_out", int'(sync_out), 0);
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    int cv[6] = '{-128, -127, -1, 0, 1, 127};

    initial begin
        @(negedge clk);
        do_reset();

        // R8: data before first sync is ignored
        for (int k = 0; k < 8; k++) step(1, 0, 100 - k * 7, -50 + k * 9);

        // R1, R9: directed pair with distinct components
        tag_force = "R9";
        step(1, 1, 5, -3);             // opening sample: still zero
        tag_force = "R1";
        step(1, 0, 1, 2);              // sum (6,-1) with frame marker
        tag_force = "R9";
        step(1, 0, 0, 0);              // difference (4,-5) on next enabled edge
        tag_force = "";
        step(1, 0, 0, 0);

        // R5: resync in the middle of a pair, then a full pair
        step(1, 0, 10, 10);            // opens a pair
        step(1, 1, 20, -20);           // abandons it, new pair starts
        tag_force = "R5";
        step(1, 0, 3, 4);              // sum 23,-16 with marker
        tag_force = "";

        // R2/R3/R4/R6: near-exhaustive corner sweep, one sync at start
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int c = 0; c < 6; c++)
                    for (int d = 0; d < 6; d++) begin
                        step(1, (a == 0 && b == 0 && c == 0 && d == 0), cv[a], cv[b]);
                        step(1, 0, cv[c], cv[d]);
                    end

        // R7: stalls with garbage and sync pulses that must be ignored
        for (int k = 0; k < 20; k++) begin
            step(0, 1, -128 + k, 127 - k);
            step(1, 0, k * 5 - 60, 40 - k * 3);
        end

        // Random traffic with stalls and occasional resync
        for (int k = 0; k < 3000; k++) begin
            bit e;
            bit s;
            int r;
            int i;
            e = ($urandom % 5) != 0;
            s = ($urandom % 300) == 0;
            r = int'($urandom % 256) - 128;
            i = int'($urandom % 256) - 128;
            step(e, s, r, i);
        end

        // R8: reset mid-run then idle data is ignored again
        do_reset();
        for (int k = 0; k < 6; k++) step(1, 0, -128, 127);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule